// File: doc/BRIEF.md
# AUX Transfer Completion Classifier

This block sits beside an AUX channel transmitter and interprets the interrupt status vector that the channel raises when a transfer ends. When a status word arrives while a command is in flight, the block reduces it to one result code and one reply kind: ACK, DEFER, NACK, or no reply for a timeout. It emits a single completion pulse that carries these values.

The block also runs a watchdog over each busy window. If nothing completes within a parameterised number of cycles, it closes the transfer as a timeout. That timeout may request a channel reset when the link is up. Native transfers that time out feed a retry counter, and every fifth such failure requests a PHY recalibration.

The host raises `busy_i` for the length of one transfer and drops it before starting the next transfer. At most one completion is produced per busy window.

Top module: `aux_status_classifier`

## Requirements
- R1: Status bit positions are: bit0 done, bit1 I2C defer, bit2 I2C NACK, bit3 timeout, bit4 wrong address, bit5 NACK-defer, bit6 PHY error. The highest-priority set bit decides the result, with priority PHY error > NACK-defer > wrong address > timeout > I2C NACK > I2C defer > done. Result codes are: 0 none, 1 address, 2 timeout, 3 NACK, 4 DEFER, 5 NACK-defer, 6 PHY. The completion pulse `cmpl_o` rises in the cycle after the status is accepted.
- R2: I2C NACK and I2C defer bits are ignored when `native_i` is high. A native status that has only those bits set produces no completion and leaves `result_o` unchanged.
- R3: In an I2C transfer, I2C defer together with done gives result NACK (3). I2C defer without done gives result DEFER (4).
- R4: A status strobe while `busy_i` is low, or with an all-zero vector, produces no completion. Only one completion occurs per busy window.
- R5: Reply encodings are: 0 ACK, 1 DEFER, 2 NACK, 3 none. Result none maps to ACK. DEFER maps to DEFER. PHY, address, NACK and NACK-defer map to NACK. Timeout maps to none.
- R6: A PHY error result pulses `clr_irq_o` together with `cmpl_o`. No other result pulses it.
- R7: A timeout pulses `timeout_o` with `cmpl_o`. A timeout comes either from the status timeout bit or from the watchdog. The watchdog completes the transfer at the TIMEOUT_CYC-th rising edge that sees `busy_i` high without a completion.
- R8: A watchdog timeout pulses `chan_rst_o` only when `link_up_i` is high. A status-driven completion never pulses it.
- R9: Each watchdog timeout of a native transfer increments a retry count. The fifth such failure pulses `recal_o` and restarts the count. Watchdog timeouts of I2C transfers leave the count unchanged. Any status-driven completion clears the count.
- R10: `multi_err_o` pulses with `cmpl_o` when more than one bit other than done is set in the accepted status.
- R11: After reset, `cmpl_o` and all pulse outputs are 0, `result_o` is 0 and `reply_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stat_i | input | 7 | Interrupt status vector |
| stat_vld_i | input | 1 | Status strobe |
| native_i | input | 1 | Current transfer is native (not I2C) |
| busy_i | input | 1 | A command is in flight |
| link_up_i | input | 1 | Link is connected |
| cmpl_o | output | 1 | Completion pulse |
| result_o | output | 3 | Result code, held until the next completion |
| reply_o | output | 2 | Reply kind, held until the next completion |
| timeout_o | output | 1 | Timeout, pulses with cmpl_o |
| recal_o | output | 1 | PHY recalibration request pulse |
| chan_rst_o | output | 1 | Channel reset request pulse |
| clr_irq_o | output | 1 | Clear hardware interrupt status pulse |
| multi_err_o | output | 1 | Several error bits were set at once |

## Verification
The hardest case to reach is the recalibration request. It needs five native watchdog failures in a row, with no status-driven completion between them. The bench shortens the watchdog to 16 cycles and chains whole busy windows that time out. It interleaves a successful transfer to show that the count restarts, and it interleaves an I2C timeout to show that the count holds. The suppression cases are also checked through the held `result_o`, which must keep the value of the earlier completion.

// File: rtl/aux_cls_pkg.sv
package aux_cls_pkg;
  localparam int STAT_W      = 7;
  localparam int B_DONE      = 0;
  localparam int B_I2C_DEFER = 1;
  localparam int B_I2C_NACK  = 2;
  localparam int B_TOUT      = 3;
  localparam int B_ADDR      = 4;
  localparam int B_NDEFER    = 5;
  localparam int B_PHY       = 6;

  typedef enum logic [2:0] {
    RES_NONE = 3'd0, RES_ADDR = 3'd1, RES_TOUT = 3'd2, RES_NACK = 3'd3,
    RES_DEFER = 3'd4, RES_NDEFER = 3'd5, RES_PHY = 3'd6
  } res_e;

  typedef enum logic [1:0] {
    RPL_ACK = 2'd0, RPL_DEFER = 2'd1, RPL_NACK = 2'd2, RPL_NONE = 2'd3
  } rpl_e;

  function automatic rpl_e reply_of(res_e r);
    case (r)
      RES_NONE:  return RPL_ACK;
      RES_DEFER: return RPL_DEFER;
      RES_TOUT:  return RPL_NONE;
      default:   return RPL_NACK;
    endcase
  endfunction
endpackage

// File: rtl/aux_cls_decode.sv
module aux_cls_decode
  import aux_cls_pkg::*;
(
  input  logic [STAT_W-1:0] stat_i,
  input  logic              native_i,
  output logic              known_o,
  output res_e              res_o,
  output logic              multi_o
);
  logic [STAT_W-1:0] errs;

  always_comb begin
    known_o = 1'b1;
    res_o   = RES_NONE;
    if (stat_i[B_PHY])                          res_o = RES_PHY;
    else if (stat_i[B_NDEFER])                  res_o = RES_NDEFER;
    else if (stat_i[B_ADDR])                    res_o = RES_ADDR;
    else if (stat_i[B_TOUT])                    res_o = RES_TOUT;
    else if (!native_i && stat_i[B_I2C_NACK])   res_o = RES_NACK;
    else if (!native_i && stat_i[B_I2C_DEFER])  res_o = stat_i[B_DONE] ? RES_NACK : RES_DEFER;
    else if (stat_i[B_DONE])                    res_o = RES_NONE;
    else                                        known_o = 1'b0;
  end

  always_comb begin
    errs         = stat_i;
    errs[B_DONE] = 1'b0;
    multi_o      = $countones(errs) > 1;
  end
endmodule

// File: rtl/aux_cls_watchdog.sv
module aux_cls_watchdog #(
  parameter int unsigned TIMEOUT_CYC = 12_500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic armed_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!armed_i) cnt_q <= '0;
    else if (!expire_o) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = armed_i && (cnt_q == CW'(TIMEOUT_CYC - 1));
endmodule

// File: rtl/aux_cls_retry.sv
module aux_cls_retry #(
  parameter int unsigned RETRY_LIM = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fail_i,
  input  logic clear_i,
  output logic recal_o
);
  localparam int unsigned RW = $clog2(RETRY_LIM + 1);
  logic [RW-1:0] cnt_q;

  assign recal_o = fail_i && (cnt_q == RW'(RETRY_LIM - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (recal_o) cnt_q <= '0;
    else if (fail_i)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/aux_status_classifier.sv
module aux_status_classifier
  import aux_cls_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 12_500_000,
  parameter int unsigned RETRY_LIM   = 5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [6:0]  stat_i,
  input  logic        stat_vld_i,
  input  logic        native_i,
  input  logic        busy_i,
  input  logic        link_up_i,
  output logic        cmpl_o,
  output logic [2:0]  result_o,
  output logic [1:0]  reply_o,
  output logic        timeout_o,
  output logic        recal_o,
  output logic        chan_rst_o,
  output logic        clr_irq_o,
  output logic        multi_err_o
);
  logic fin_q, armed, known, multi, accept, expire, wd_fail, recal_req;
  res_e dec_res;

  aux_cls_decode u_dec (
    .stat_i  (stat_i),
    .native_i(native_i),
    .known_o (known),
    .res_o   (dec_res),
    .multi_o (multi)
  );

  assign armed   = busy_i && !fin_q;
  assign accept  = armed && stat_vld_i && (|stat_i) && known;
  assign wd_fail = expire && !accept;

  aux_cls_watchdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .armed_i (armed),
    .expire_o(expire)
  );

  aux_cls_retry #(.RETRY_LIM(RETRY_LIM)) u_retry (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fail_i (wd_fail && native_i),
    .clear_i(accept),
    .recal_o(recal_req)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fin_q       <= 1'b0;
      cmpl_o      <= 1'b0;
      result_o    <= RES_NONE;
      reply_o     <= RPL_ACK;
      timeout_o   <= 1'b0;
      recal_o     <= 1'b0;
      chan_rst_o  <= 1'b0;
      clr_irq_o   <= 1'b0;
      multi_err_o <= 1'b0;
    end else begin
      cmpl_o      <= accept || wd_fail;
      timeout_o   <= (accept && dec_res == RES_TOUT) || wd_fail;
      recal_o     <= recal_req;
      chan_rst_o  <= wd_fail && link_up_i;
      clr_irq_o   <= accept && dec_res == RES_PHY;
      multi_err_o <= accept && multi;
      if (!busy_i)                 fin_q <= 1'b0;
      else if (accept || wd_fail)  fin_q <= 1'b1;
      if (accept) begin
        result_o <= dec_res;
        reply_o  <= reply_of(dec_res);
      end else if (wd_fail) begin
        result_o <= RES_TOUT;
        reply_o  <= RPL_NONE;
      end
    end
  end
endmodule

// File: rtl/aux_cls_chk.sv
module aux_cls_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_i,
  input logic       link_up_i,
  input logic       cmpl_o,
  input logic [2:0] result_o,
  input logic [1:0] reply_o,
  input logic       timeout_o,
  input logic       recal_o,
  input logic       chan_rst_o,
  input logic       clr_irq_o,
  input logic       multi_err_o
);
  // R4
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> !cmpl_o);
  // R4
  single_cmpl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmpl_o |=> !cmpl_o);
  // R6
  clr_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_irq_o |-> cmpl_o && result_o == 3'd6);
  // R5
  defer_reply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmpl_o && result_o == 3'd4 |-> reply_o == 2'd1);
  // R7
  tout_reply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> cmpl_o && result_o == 3'd2 && reply_o == 2'd3);
  // R8
  chan_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_rst_o |-> timeout_o);
  // R9
  recal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recal_o |-> timeout_o && !clr_irq_o);
  // R10
  multi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_err_o |-> cmpl_o);
endmodule

bind aux_status_classifier aux_cls_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy_i), .link_up_i(link_up_i),
  .cmpl_o(cmpl_o), .result_o(result_o), .reply_o(reply_o),
  .timeout_o(timeout_o), .recal_o(recal_o), .chan_rst_o(chan_rst_o),
  .clr_irq_o(clr_irq_o), .multi_err_o(multi_err_o)
);

// File: tb/aux_status_classifier_bench.sv
module aux_status_classifier_bench;
  localparam int unsigned TCYC = 16;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic [6:0] stat_i = '0;
  logic       stat_vld_i = 1'b0, native_i = 1'b0, busy_i = 1'b0, link_up_i = 1'b0;
  logic       cmpl_o, timeout_o, recal_o, chan_rst_o, clr_irq_o, multi_err_o;
  logic [2:0] result_o;
  logic [1:0] reply_o;
  int n_chk = 0, n_fail = 0;

  always #10 clk_i = ~clk_i;

  aux_status_classifier #(.TIMEOUT_CYC(TCYC), .RETRY_LIM(5)) u_aux_status_classifier (
    .clk_i, .rst_ni, .stat_i, .stat_vld_i, .native_i, .busy_i, .link_up_i,
    .cmpl_o, .result_o, .reply_o, .timeout_o, .recal_o, .chan_rst_o,
    .clr_irq_o, .multi_err_o
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    check(act == exp, tag, act, exp);
  endtask

  // status transfer; samples at negedge after the accepting edge
  task automatic xfer(input logic [6:0] s, input logic nat, output logic got);
    @(negedge clk_i);
    busy_i = 1; native_i = nat; stat_i = s; stat_vld_i = 1;
    @(negedge clk_i);
    stat_vld_i = 0; stat_i = '0;
    got = cmpl_o;
  endtask

  task automatic end_xfer();
    @(negedge clk_i);
    busy_i = 0;
    @(negedge clk_i);
  endtask

  task automatic expect_cls(input logic [6:0] s, input logic nat, input int res, input int rpl, input string tag);
    logic got;
    xfer(s, nat, got);
    chk_eq({tag, " cmpl"}, got, 1);
    chk_eq({tag, " result"}, result_o, res);
    chk_eq({tag, " reply"}, reply_o, rpl);
    end_xfer();
  endtask

  // watchdog timeout; returns recal/chan_rst seen with completion
  task automatic wd_timeout(input logic nat, input logic link, output logic rc, output logic cr);
    @(negedge clk_i);
    busy_i = 1; native_i = nat; link_up_i = link;
    repeat (TCYC) @(posedge clk_i);
    @(negedge clk_i);
    rc = recal_o; cr = chan_rst_o;
    chk_eq("R7 wd cmpl", cmpl_o, 1);
    chk_eq("R7 wd timeout", timeout_o, 1);
    chk_eq("R7 wd result", result_o, 2);
    end_xfer();
  endtask

  task t_reset();
    chk_eq("R11 cmpl", cmpl_o, 0);
    chk_eq("R11 result", result_o, 0);
    chk_eq("R11 reply", reply_o, 0);
    chk_eq("R11 pulses", {timeout_o, recal_o, chan_rst_o, clr_irq_o, multi_err_o}, 0);
  endtask

  task t_priority();
    expect_cls(7'h7F, 0, 6, 2, "R1 all bits->PHY");
    expect_cls(7'h3F, 0, 5, 2, "R1 ndefer");
    expect_cls(7'h1F, 0, 1, 2, "R1 addr");
    expect_cls(7'h0F, 1, 2, 3, "R1 tout");
    expect_cls(7'h07, 0, 3, 2, "R1 i2c nack");
    expect_cls(7'h01, 1, 0, 0, "R5 done->ACK");
  endtask

  task t_native_mask();
    logic got;
    expect_cls(7'h05, 1, 0, 0, "R2 native nack masked");
    xfer(7'h06, 1, got);
    chk_eq("R2 native i2c-only ignored", got, 0);
    chk_eq("R2 result held", result_o, 0);
    end_xfer();
  endtask

  task t_defer();
    expect_cls(7'h03, 0, 3, 2, "R3 defer+done->NACK");
    expect_cls(7'h02, 0, 4, 1, "R3 defer->DEFER");
  endtask

  task t_ignore();
    logic got;
    @(negedge clk_i);
    busy_i = 0; stat_i = 7'h40; stat_vld_i = 1;
    @(negedge clk_i);
    stat_vld_i = 0;
    @(negedge clk_i);
    chk_eq("R4 not busy", cmpl_o, 0);
    chk_eq("R4 not busy result held", result_o, 4);
    xfer(7'h00, 0, got);
    chk_eq("R4 zero status", got, 0);
    chk_eq("R4 zero result held", result_o, 4);
    end_xfer();
    xfer(7'h01, 0, got);
    chk_eq("R4 first cmpl", got, 1);
    @(negedge clk_i);
    stat_i = 7'h40; stat_vld_i = 1;
    @(negedge clk_i);
    stat_vld_i = 0;
    chk_eq("R4 second in window", cmpl_o, 0);
    chk_eq("R4 second result held", result_o, 0);
    end_xfer();
  endtask

  task t_phy();
    logic got;
    xfer(7'h41, 0, got);
    chk_eq("R6 clr_irq on PHY", clr_irq_o, 1);
    end_xfer();
    xfer(7'h10, 0, got);
    chk_eq("R6 no clr_irq on addr", clr_irq_o, 0);
    end_xfer();
  endtask

  task t_tout_bit();
    logic got;
    xfer(7'h09, 0, got);
    chk_eq("R7 status tout pulse", timeout_o, 1);
    chk_eq("R8 no chan_rst on status tout", chan_rst_o, 0);
    end_xfer();
  endtask

  task t_watchdog();
    logic rc, cr;
    @(negedge clk_i);
    busy_i = 1; native_i = 0; link_up_i = 1;
    repeat (TCYC - 1) @(posedge clk_i);
    @(negedge clk_i);
    chk_eq("R7 no early timeout", cmpl_o, 0);
    end_xfer();
    wd_timeout(0, 1, rc, cr);
    chk_eq("R8 chan_rst link up", cr, 1);
    wd_timeout(0, 0, rc, cr);
    chk_eq("R8 no chan_rst link down", cr, 0);
  endtask

  task t_retry();
    logic rc, cr, got;
    for (int i = 0; i < 4; i++) begin
      wd_timeout(1, 0, rc, cr);
      chk_eq("R9 no recal before fifth", rc, 0);
    end
    wd_timeout(1, 0, rc, cr);
    chk_eq("R9 recal on fifth", rc, 1);
    for (int i = 0; i < 3; i++) wd_timeout(1, 0, rc, cr);
    xfer(7'h01, 1, got);
    end_xfer();
    for (int i = 0; i < 4; i++) begin
      wd_timeout(1, 0, rc, cr);
      chk_eq("R9 count cleared by success", rc, 0);
    end
    wd_timeout(0, 0, rc, cr);
    chk_eq("R9 i2c timeout not counted", rc, 0);
    wd_timeout(1, 0, rc, cr);
    chk_eq("R9 recal after i2c gap", rc, 1);
  endtask

  task t_multi();
    logic got;
    xfer(7'h11, 0, got);
    chk_eq("R10 single err", multi_err_o, 0);
    end_xfer();
    xfer(7'h18, 0, got);
    chk_eq("R10 two errs", multi_err_o, 1);
    end_xfer();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    @(negedge clk_i);
    t_priority();
    t_native_mask();
    t_defer();
    t_ignore();
    t_phy();
    t_tout_bit();
    t_watchdog();
    t_multi();
    t_retry();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule